// File: doc/BRIEF.md
# SPI Serial ROM Command Controller

This block is the command engine that sits behind the bit-level serial front end of a byte-organised serial memory of 64K bytes. The front end hands it whole bytes with a one-cycle strobe while the chip select is active. The first byte after select is asserted is an opcode. Depending on the opcode, the block either collects a three-byte address and streams memory bytes out through a synchronous read port, collects an address and writes the incoming data bytes through a write port, repeats a fixed status byte, or returns two identification bytes.

Every outgoing byte is handed to the front end's output shift register with a one-cycle load pulse. An output-enable flag tells the front end when to drive the serial output line. Opcodes it does not recognise leave the block silent until select is released. Programming is accepted only while a qualifying enable input is high; that input stands in for the presence of the programming supply.

Top module: `spi_rom_cmd_ctrl`

## Requirements
- R1: After reset the engine drives nothing, and it ignores byte strobes until it has seen select deasserted at least once.
- R2: The first byte after select is asserted is decoded as the opcode. Bit 3 is a don't-care for read (0000_x011), status (0000_x101) and ID (0001_x101). Program is exactly 99h.
- R3: After a read opcode, three address bytes follow. The first is discarded, the second gives address bits 15:8 and the third gives bits 7:0. mem_rd_en_o is high, with that address, in the cycle after the third byte's strobe edge. tx_load_o with the returned data follows three cycles after that strobe edge.
- R4: While read data is streaming, every further byte strobe requests the next sequential address and ignores the content of the incoming byte.
- R5: During both read and program streaming, the address advances from FFFFh to 0000h.
- R6: A status opcode loads 8Ch one cycle after its strobe edge and loads 8Ch again after every later strobe. tx_oe_o is high meanwhile.
- R7: An ID opcode loads 1Ch one cycle after its strobe edge. Every later strobe loads 83h.
- R8: With prog_en_i high, 99h is followed by three address bytes. Each later data byte causes one write, one cycle after its strobe edge, to the current address with that byte; the address then increments.
- R9: With prog_en_i low, 99h is treated as an unknown opcode: no write, no load and no output drive.
- R10: After an unknown opcode there is no load, no memory access and no output drive until select is deasserted.
- R11: Deasserting select drops tx_oe_o in the next cycle and discards any partly collected address. The next command is then decoded afresh from its first byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sel_i | input | 1 | Chip select active (1 = selected) |
| byte_vld_i | input | 1 | One-cycle strobe: a full byte has been shifted |
| byte_i | input | 8 | Byte shifted in, MSB first on the wire |
| prog_en_i | input | 1 | Programming permitted |
| mem_rd_en_o | output | 1 | Synchronous memory read request |
| mem_rd_addr_o | output | AW | Read address |
| mem_rd_data_i | input | 8 | Read data, valid the cycle after the request |
| mem_wr_en_o | output | 1 | Memory write strobe |
| mem_wr_addr_o | output | AW | Write address |
| mem_wr_data_o | output | 8 | Write data |
| tx_load_o | output | 1 | Load pulse for the output shift register |
| tx_byte_o | output | 8 | Byte to load |
| tx_oe_o | output | 1 | Serial output driven |

## Verification
The timing of each result is fixed. Status and ID loads, write strobes and read requests appear one cycle after the strobe edge that causes them. A read byte is loaded three cycles after its strobe edge: one cycle for the request, one for the memory and one for the load register. A falling-edge monitor in the bench counts every load, read request and write and records the last values seen. Each directed task then checks the counters on exactly those falling edges, which catches a missing pulse, an extra pulse or a pulse in the wrong cycle. Silence cases are checked by comparing the counters before and after the stimulus and by reading tx_oe_o.

// File: rtl/spi_rom_pkg.sv
package spi_rom_pkg;
  localparam int BYTE_W = 8;

  localparam logic [7:0] OPC_MASK = 8'hF7;  // bit 3 don't-care
  localparam logic [7:0] OPC_READ = 8'h03;
  localparam logic [7:0] OPC_STAT = 8'h05;
  localparam logic [7:0] OPC_ID   = 8'h15;
  localparam logic [7:0] OPC_PROG = 8'h99;

  localparam logic [7:0] STAT_VAL = 8'h8C;
  localparam logic [7:0] MFR_CODE = 8'h1C;
  localparam logic [7:0] DEV_CODE = 8'h83;

  typedef enum logic [2:0] {
    ST_IDLE, ST_OPC, ST_ADDR, ST_RDATA, ST_STAT, ST_ID, ST_PDATA, ST_INV
  } st_e;

  typedef enum logic [2:0] {
    CMD_NONE, CMD_READ, CMD_STAT, CMD_ID, CMD_PROG
  } cmd_e;
endpackage

// File: rtl/spi_rom_opc_dec.sv
module spi_rom_opc_dec
  import spi_rom_pkg::*;
(
  input  logic [BYTE_W-1:0] opc_i,
  input  logic              prog_en_i,
  output cmd_e              cmd_o
);
  always_comb begin
    cmd_o = CMD_NONE;
    if      ((opc_i & OPC_MASK) == OPC_READ) cmd_o = CMD_READ;
    else if ((opc_i & OPC_MASK) == OPC_STAT) cmd_o = CMD_STAT;
    else if ((opc_i & OPC_MASK) == OPC_ID)   cmd_o = CMD_ID;
    else if (opc_i == OPC_PROG && prog_en_i) cmd_o = CMD_PROG;
  end
endmodule

// File: rtl/spi_rom_addr_reg.sv
module spi_rom_addr_reg
  import spi_rom_pkg::*;
#(
  parameter int AW         = 16,
  parameter int ADDR_BYTES = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              shift_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              inc_i,
  output logic [AW-1:0]     addr_o,
  output logic              last_o
);
  localparam int CW = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1;

  logic [CW-1:0] cnt_q;
  logic [AW-1:0] addr_q;

  assign addr_o = addr_q;
  assign last_o = shift_i && (cnt_q == CW'(ADDR_BYTES - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      addr_q <= '0;
    end else begin
      if (clr_i) cnt_q <= '0;
      else if (shift_i) cnt_q <= cnt_q + 1'b1;
      // upper address bytes fall off the top
      if (shift_i) addr_q <= AW'({addr_q, byte_i});
      else if (inc_i) addr_q <= addr_q + 1'b1;
    end
  end

  assert_addr_wrap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !shift_i && addr_q == '1) |=> addr_q == '0)
    else $error("address did not wrap to zero");
endmodule

// File: rtl/spi_rom_cmd_ctrl.sv
module spi_rom_cmd_ctrl
  import spi_rom_pkg::*;
#(
  parameter int AW         = 16,
  parameter int ADDR_BYTES = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              byte_vld_i,
  input  logic [7:0]        byte_i,
  input  logic              prog_en_i,
  output logic              mem_rd_en_o,
  output logic [AW-1:0]     mem_rd_addr_o,
  input  logic [7:0]        mem_rd_data_i,
  output logic              mem_wr_en_o,
  output logic [AW-1:0]     mem_wr_addr_o,
  output logic [7:0]        mem_wr_data_o,
  output logic              tx_load_o,
  output logic [7:0]        tx_byte_o,
  output logic              tx_oe_o
);
  st_e               st_q;
  cmd_e              cmd;
  logic              prog_q, rd_pend_q, rd_wait_q;
  logic              tx_load_q, wr_en_q;
  logic [7:0]        tx_byte_q, wr_data_q;
  logic [AW-1:0]     wr_addr_q, addr;
  logic              addr_last, addr_shift, addr_inc, stb;

  assign stb        = byte_vld_i && sel_i;
  assign addr_shift = stb && (st_q == ST_ADDR);
  assign addr_inc   = rd_pend_q || (stb && st_q == ST_PDATA);

  spi_rom_opc_dec u_dec (
    .opc_i     (byte_i),
    .prog_en_i (prog_en_i),
    .cmd_o     (cmd)
  );

  spi_rom_addr_reg #(.AW(AW), .ADDR_BYTES(ADDR_BYTES)) u_addr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (st_q != ST_ADDR),
    .shift_i (addr_shift),
    .byte_i  (byte_i),
    .inc_i   (addr_inc),
    .addr_o  (addr),
    .last_o  (addr_last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      prog_q    <= 1'b0;
      rd_pend_q <= 1'b0;
      rd_wait_q <= 1'b0;
      tx_load_q <= 1'b0;
      tx_byte_q <= '0;
      wr_en_q   <= 1'b0;
      wr_addr_q <= '0;
      wr_data_q <= '0;
    end else begin
      tx_load_q <= 1'b0;
      wr_en_q   <= 1'b0;
      rd_pend_q <= 1'b0;
      rd_wait_q <= rd_pend_q && sel_i;
      if (!sel_i) begin
        st_q <= ST_OPC;
      end else begin
        unique case (st_q)
          ST_OPC: if (byte_vld_i) begin
            unique case (cmd)
              CMD_READ: begin st_q <= ST_ADDR; prog_q <= 1'b0; end
              CMD_PROG: begin st_q <= ST_ADDR; prog_q <= 1'b1; end
              CMD_STAT: begin
                st_q <= ST_STAT; tx_load_q <= 1'b1; tx_byte_q <= STAT_VAL;
              end
              CMD_ID: begin
                st_q <= ST_ID; tx_load_q <= 1'b1; tx_byte_q <= MFR_CODE;
              end
              default: st_q <= ST_INV;
            endcase
          end
          ST_ADDR: if (byte_vld_i && addr_last) begin
            st_q      <= prog_q ? ST_PDATA : ST_RDATA;
            rd_pend_q <= !prog_q;
          end
          ST_RDATA: if (byte_vld_i) rd_pend_q <= 1'b1;
          ST_STAT: if (byte_vld_i) begin
            tx_load_q <= 1'b1; tx_byte_q <= STAT_VAL;
          end
          ST_ID: if (byte_vld_i) begin
            tx_load_q <= 1'b1; tx_byte_q <= DEV_CODE;
          end
          ST_PDATA: if (byte_vld_i) begin
            wr_en_q <= 1'b1; wr_addr_q <= addr; wr_data_q <= byte_i;
          end
          default: ;
        endcase
      end
      if (rd_wait_q && sel_i) begin
        tx_load_q <= 1'b1;
        tx_byte_q <= mem_rd_data_i;
      end
    end
  end

  assign mem_rd_en_o   = rd_pend_q;
  assign mem_rd_addr_o = addr;
  assign mem_wr_en_o   = wr_en_q;
  assign mem_wr_addr_o = wr_addr_q;
  assign mem_wr_data_o = wr_data_q;
  assign tx_load_o     = tx_load_q;
  assign tx_byte_o     = tx_byte_q;
  assign tx_oe_o       = (st_q == ST_RDATA) || (st_q == ST_STAT) || (st_q == ST_ID);

  assert_deselect_quiet_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_i |=> !tx_oe_o)
    else $error("output still driven after deselect");

  assert_wr_after_strobe_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_wr_en_o |-> $past(byte_vld_i && sel_i))
    else $error("write without preceding strobe");

  assert_status_value_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_load_o && st_q == ST_STAT) |-> tx_byte_o == STAT_VAL)
    else $error("status load carries wrong value");

  assert_rd_to_load_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_rd_en_o && sel_i) ##1 sel_i |=> tx_load_o)
    else $error("read data not loaded");

  assert_inv_silent_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_INV) |-> !(tx_oe_o || mem_rd_en_o || mem_wr_en_o || tx_load_o))
    else $error("activity after unknown opcode");
endmodule

// File: tb/sim_spi_rom_cmd_ctrl.sv
`timescale 1ns/1ps
module sim_spi_rom_cmd_ctrl;
  localparam int AW = 16;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic sel_i = 1'b1, byte_vld_i = 1'b0, prog_en_i = 1'b0;
  logic [7:0] byte_i = '0;
  logic mem_rd_en_o, mem_wr_en_o, tx_load_o, tx_oe_o;
  logic [AW-1:0] mem_rd_addr_o, mem_wr_addr_o;
  logic [7:0] mem_rd_data_i = '0, mem_wr_data_o, tx_byte_o;

  int n_chk = 0, n_err = 0;
  int n_load = 0, n_rd = 0, n_wr = 0;
  logic [7:0] last_tx = '0, last_wd = '0;
  logic [AW-1:0] last_ra = '0, last_wa = '0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  spi_rom_cmd_ctrl #(.AW(AW), .ADDR_BYTES(3)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .sel_i(sel_i), .byte_vld_i(byte_vld_i),
    .byte_i(byte_i), .prog_en_i(prog_en_i),
    .mem_rd_en_o(mem_rd_en_o), .mem_rd_addr_o(mem_rd_addr_o),
    .mem_rd_data_i(mem_rd_data_i),
    .mem_wr_en_o(mem_wr_en_o), .mem_wr_addr_o(mem_wr_addr_o),
    .mem_wr_data_o(mem_wr_data_o),
    .tx_load_o(tx_load_o), .tx_byte_o(tx_byte_o), .tx_oe_o(tx_oe_o)
  );

  function automatic logic [7:0] mem_f(input logic [AW-1:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  always @(posedge clk) if (mem_rd_en_o) mem_rd_data_i <= mem_f(mem_rd_addr_o);

  always @(negedge clk) begin
    if (tx_load_o)   begin n_load++; last_tx = tx_byte_o; end
    if (mem_rd_en_o) begin n_rd++;   last_ra = mem_rd_addr_o; end
    if (mem_wr_en_o) begin n_wr++;   last_wa = mem_wr_addr_o; last_wd = mem_wr_data_o; end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk); byte_i = b; byte_vld_i = 1'b1;
    @(negedge clk); byte_vld_i = 1'b0;
    #1;
  endtask

  task automatic begin_cmd;
    @(negedge clk); sel_i = 1'b0;
    @(negedge clk); sel_i = 1'b1;
    #1;
  endtask

  task automatic end_cmd;
    @(negedge clk); sel_i = 1'b0;
    wait_cyc(1);
  endtask

  task automatic t_reset;
    int l0;
    chk("R1 oe after reset", tx_oe_o, 0);
    l0 = n_load;
    send(8'h05);
    wait_cyc(1);
    chk("R1 strobe before deselect ignored", n_load - l0, 0);
    chk("R1 oe stays low", tx_oe_o, 0);
    end_cmd();
  endtask

  task automatic t_status;
    int l0;
    begin_cmd(); l0 = n_load;
    send(8'h05);
    chk("R6 first status load", n_load - l0, 1);
    chk("R6 status value", last_tx, 8'h8C);
    chk("R6 oe during status", tx_oe_o, 1);
    send(8'hA5);
    send(8'h3C);
    chk("R6 status repeats", n_load - l0, 3);
    chk("R6 repeated value", last_tx, 8'h8C);
    end_cmd();
    chk("R11 oe drops on deselect", tx_oe_o, 0);
    begin_cmd();
    send(8'h0D);
    chk("R2 status with bit3 set", last_tx, 8'h8C);
    end_cmd();
  endtask

  task automatic t_id;
    begin_cmd();
    send(8'h15);
    chk("R7 manufacturer code", last_tx, 8'h1C);
    send(8'h00);
    chk("R7 device code", last_tx, 8'h83);
    send(8'hFF);
    chk("R7 device code held", last_tx, 8'h83);
    end_cmd();
    begin_cmd();
    send(8'h1D);
    chk("R2 ID with bit3 set", last_tx, 8'h1C);
    end_cmd();
  endtask

  task automatic t_read;
    int r0, l0;
    begin_cmd();
    send(8'h03); send(8'h7E); send(8'h12);
    r0 = n_rd; l0 = n_load;
    send(8'h34);
    chk("R3 read request issued", n_rd - r0, 1);
    chk("R3 read address", last_ra, 16'h1234);
    chk("R3 no load yet", n_load - l0, 0);
    wait_cyc(2);
    chk("R3 data loaded", last_tx, mem_f(16'h1234));
    send(8'hFF);
    chk("R4 next address", last_ra, 16'h1235);
    wait_cyc(2);
    chk("R4 next data", last_tx, mem_f(16'h1235));
    chk("R4 load count", n_load - l0, 2);
    end_cmd();
  endtask

  task automatic t_read_wrap;
    begin_cmd();
    send(8'h0B); send(8'h00); send(8'hFF); send(8'hFF);
    chk("R5 read top address", last_ra, 16'hFFFF);
    wait_cyc(2);
    send(8'h00);
    chk("R5 read wraps to zero", last_ra, 16'h0000);
    wait_cyc(2);
    chk("R5 wrapped data", last_tx, mem_f(16'h0000));
    end_cmd();
  endtask

  task automatic t_prog;
    int w0;
    prog_en_i = 1'b1;
    begin_cmd();
    send(8'h99); send(8'h00); send(8'h40); send(8'h00);
    w0 = n_wr;
    send(8'h11);
    chk("R8 first write", n_wr - w0, 1);
    chk("R8 write address", last_wa, 16'h4000);
    chk("R8 write data", last_wd, 8'h11);
    send(8'h22);
    chk("R8 address increments", last_wa, 16'h4001);
    chk("R8 second data", last_wd, 8'h22);
    end_cmd();
    begin_cmd();
    send(8'h99); send(8'h00); send(8'hFF); send(8'hFF);
    send(8'h33);
    chk("R5 program top address", last_wa, 16'hFFFF);
    send(8'h44);
    chk("R5 program wraps", last_wa, 16'h0000);
    chk("R5 program wrap data", last_wd, 8'h44);
    end_cmd();
    prog_en_i = 1'b0;
  endtask

  task automatic t_prog_dis;
    int w0, l0;
    begin_cmd(); w0 = n_wr; l0 = n_load;
    send(8'h99); send(8'h00); send(8'h40); send(8'h00); send(8'h55);
    wait_cyc(2);
    chk("R9 no write when disabled", n_wr - w0, 0);
    chk("R9 no load when disabled", n_load - l0, 0);
    chk("R9 no drive when disabled", tx_oe_o, 0);
    end_cmd();
  endtask

  task automatic t_invalid;
    int l0, r0;
    begin_cmd(); l0 = n_load; r0 = n_rd;
    send(8'h01); send(8'h03); send(8'h05); send(8'h00);
    wait_cyc(3);
    chk("R10 no load after unknown opcode", n_load - l0, 0);
    chk("R10 no read after unknown opcode", n_rd - r0, 0);
    chk("R10 no drive after unknown opcode", tx_oe_o, 0);
    end_cmd();
    begin_cmd();
    send(8'h05);
    chk("R11 fresh decode after unknown", last_tx, 8'h8C);
    end_cmd();
  endtask

  task automatic t_abort;
    int r0;
    begin_cmd(); r0 = n_rd;
    send(8'h03); send(8'h00); send(8'h12);
    end_cmd();
    begin_cmd();
    send(8'h05);
    chk("R11 partial address discarded", n_rd - r0, 0);
    chk("R11 new opcode decoded", last_tx, 8'h8C);
    end_cmd();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    wait_cyc(1);
    t_reset();
    t_status();
    t_id();
    t_read();
    t_read_wrap();
    t_prog();
    t_prog_dis();
    t_invalid();
    t_abort();
    wait_cyc(2);
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule